// File: doc/BRIEF.md
# Saturating Up/Down Counter Voter for Weak-PUF Cells

This block settles the bit of each cell in a small group of noisy weak-PUF cells. It does not count ones over a fixed window. Instead it feeds repeated evaluation samples of a cell into one saturating up/down counter. A sample of 1 moves the counter up and a sample of 0 moves it down. The counter starts each cell at its midpoint, and either end of the range is absorbing. A cell whose noise has a clear bias reaches an end and is resolved. A cell with no clear bias may drift until the trial budget is spent, and it is then reported as unresolved.

One counter serves the whole group. The group's sample bits arrive as a vector. An internal select multiplexer picks the bit of the current cell, and the cells are handled in ascending index order. A sample-valid strobe marks each captured evaluation. The surrounding logic raises this strobe from a delayed clock, after the precharge/evaluate phase of the cell has settled. Every cell gets a fixed number of trial slots, so one pass over the group always takes the same number of valid strobes. After each cell, a one-cycle result pulse reports the cell index, the decided bit and whether a decision was reached.

Top module: `pufv_voter`

## Requirements
- R1: While reset is high and in the first cycle after it falls, busy and done are 0.
- R2: At the start of each cell, the counter is preset to (2^CNT_W - 2)/2, which is 7 for the default CNT_W = 4. From the preset, 7 consecutive 1 samples reach the top end, but 6 consecutive 1 samples do not.
- R3: A valid sample of 1 adds one to the counter, and a valid sample of 0 subtracts one, while the counter is between its ends.
- R4: The ends are 0 and 2^CNT_W - 2 (14 by default). Once the counter reaches an end, it holds that value for the rest of the cell's slots, and later samples of either value have no effect on the result.
- R5: A cell whose counter ends at 14 is reported with done_resolved = 1 and done_bit = 1. A cell whose counter ends at 0 is reported with done_resolved = 1 and done_bit = 0.
- R6: A cell that has reached neither end after TRIAL_BUDGET (default 50) valid samples is reported with done_resolved = 0 and done_bit = 0. An end first reached on the last slot still counts as resolved.
- R7: During cell i, cell_idx equals i, and only bit i of samp_bits affects the result for that cell.
- R8: Each cell gets exactly TRIAL_BUDGET valid samples. done is high for exactly the one cycle after the clock edge that takes the cell's last sample, and at that time done_idx carries the cell's index. Cells are served in order 0 to NUM_CELLS-1.
- R9: A start pulse while idle begins a pass and raises busy on the next cycle. busy falls in the same cycle as the done pulse of the last cell. A start pulse while busy has no effect.
- R10: samp_valid cycles while idle, and cycles with samp_valid low, neither count as trials nor change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass over the group (ignored while busy) |
| samp_valid | input | 1 | Delayed capture strobe: samp_bits holds settled evaluations |
| samp_bits | input | NUM_CELLS | Evaluation bit of every cell of the group |
| cell_idx | output | $clog2(NUM_CELLS) | Index of the cell currently being voted |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse: a cell has finished |
| done_idx | output | $clog2(NUM_CELLS) | Index of the finished cell |
| done_bit | output | 1 | Decided bit (0 when unresolved) |
| done_resolved | output | 1 | 1 when the counter reached an end |

## Verification
A wrong preset, a wrong step or a leaky end shows up only as a wrong done_bit or done_resolved. It appears on the done pulse of the affected cell, up to TRIAL_BUDGET strobes later. The directed sequences are chosen so that a preset off by one flips the result: one cell reaches an end on its 49th sample, and another misses an end by a single step. A wrong slot count or a wrong index sequence moves the done pulse or changes done_idx and cell_idx, which is visible at once on the first cell. Random biased streams run alongside, while the unselected cells' bits toggle, so a mux that reads the wrong cell corrupts the results.

// File: rtl/pufv_pkg.sv
package pufv_pkg;
  // highest counter value, an absorbing end
  function automatic int top_val(input int w);
    return (1 << w) - 2;
  endfunction
  // preset value loaded at the start of every cell
  function automatic int mid_val(input int w);
    return ((1 << w) - 2) / 2;
  endfunction
endpackage

// File: rtl/pufv_cell_mux.sv
module pufv_cell_mux #(
  parameter int NUM_CELLS = 4,
  localparam int IDX_W = $clog2(NUM_CELLS)
) (
  input  logic [NUM_CELLS-1:0] bits,
  input  logic [IDX_W-1:0]     sel,
  output logic                 y
);
  logic [NUM_CELLS-1:0] hit;
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_hit
    assign hit[g] = bits[g] && (sel == IDX_W'(g));
  end
  assign y = |hit;
endmodule

// File: rtl/pufv_sat_counter.sv
module pufv_sat_counter
  import pufv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             up,
  output logic [CNT_W-1:0] val,
  output logic             nx_lo,
  output logic             nx_hi
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(top_val(CNT_W));
  localparam logic [CNT_W-1:0] MID_V = CNT_W'(mid_val(CNT_W));

  logic             at_end;
  logic [CNT_W-1:0] val_nx;

  assign at_end = (val == '0) || (val == TOP_V);

  always_comb begin
    val_nx = val;
    if (step && !at_end) begin
      if (up) val_nx = val + 1'b1;
      else    val_nx = val - 1'b1;
    end
  end

  assign nx_lo = (val_nx == '0);
  assign nx_hi = (val_nx == TOP_V);

  always_ff @(posedge clk) begin
    if (rst)       val <= MID_V;
    else if (load) val <= MID_V;
    else           val <= val_nx;
  end

  // R4
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst) val <= TOP_V);
  // R4
  hold_top_chk: assert property (@(posedge clk) disable iff (rst)
    (val == TOP_V && !load) |=> (val == TOP_V));
  // R4
  hold_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (val == '0 && !load) |=> (val == '0));
  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((val == $past(val)) || (val == $past(val) + 1'b1) || (val + 1'b1 == $past(val))));
endmodule

// File: rtl/pufv_trial_timer.sv
module pufv_trial_timer #(
  parameter int BUDGET = 50,
  localparam int TW = $clog2(BUDGET + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last
);
  logic [TW-1:0] cnt;

  assign last = (cnt == TW'(BUDGET - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (rst) cnt < TW'(BUDGET));
endmodule

// File: rtl/pufv_voter.sv
module pufv_voter #(
  parameter int CNT_W        = 4,
  parameter int NUM_CELLS    = 4,
  parameter int TRIAL_BUDGET = 50,
  localparam int IDX_W = $clog2(NUM_CELLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 samp_valid,
  input  logic [NUM_CELLS-1:0] samp_bits,
  output logic [IDX_W-1:0]     cell_idx,
  output logic                 busy,
  output logic                 done,
  output logic [IDX_W-1:0]     done_idx,
  output logic                 done_bit,
  output logic                 done_resolved
);
  logic             cell_bit, take, slot_last, last_slot, last_cell, go, load;
  logic             nx_lo, nx_hi;
  logic [CNT_W-1:0] cnt_val;

  assign go        = start && !busy;
  assign take      = busy && samp_valid;
  assign last_slot = take && slot_last;
  assign last_cell = (cell_idx == IDX_W'(NUM_CELLS - 1));
  assign load      = go || last_slot;

  pufv_cell_mux #(.NUM_CELLS(NUM_CELLS)) u_mux (
    .bits(samp_bits), .sel(cell_idx), .y(cell_bit)
  );

  pufv_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .step(take), .up(cell_bit),
    .val(cnt_val), .nx_lo(nx_lo), .nx_hi(nx_hi)
  );

  pufv_trial_timer #(.BUDGET(TRIAL_BUDGET)) u_tmr (
    .clk(clk), .rst(rst), .clr(load), .tick(take), .last(slot_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      done          <= 1'b0;
      cell_idx      <= '0;
      done_idx      <= '0;
      done_bit      <= 1'b0;
      done_resolved <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy     <= 1'b1;
        cell_idx <= '0;
      end else if (last_slot) begin
        done          <= 1'b1;
        done_idx      <= cell_idx;
        done_bit      <= nx_hi;
        done_resolved <= nx_hi || nx_lo;
        if (last_cell) begin
          busy     <= 1'b0;
          cell_idx <= '0;
        end else begin
          cell_idx <= cell_idx + 1'b1;
        end
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R6
  unresolved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_resolved) |-> !done_bit);
  // R8
  done_in_pass_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_slot) |=> (busy && $stable(cell_idx)));
endmodule

// File: tb/pufv_voter_bench.sv
module pufv_voter_bench;
  localparam int CLK_NS = 10;
  localparam int CW     = 4;
  localparam int NC     = 4;
  localparam int BUD    = 50;
  localparam int TOPV   = (1 << CW) - 2;
  localparam int MIDV   = TOPV / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          samp_valid = 1'b0;
  logic [NC-1:0] samp_bits = '0;
  logic [1:0]    cell_idx, done_idx;
  logic          busy, done, done_bit, done_resolved;

  int checks = 0;
  int fails  = 0;
  logic [BUD-1:0] seq [NC];

  always #(CLK_NS/2) clk = ~clk;

  pufv_voter #(.CNT_W(CW), .NUM_CELLS(NC), .TRIAL_BUDGET(BUD)) u_pufv_voter (
    .clk(clk), .rst(rst), .start(start), .samp_valid(samp_valid), .samp_bits(samp_bits),
    .cell_idx(cell_idx), .busy(busy), .done(done), .done_idx(done_idx),
    .done_bit(done_bit), .done_resolved(done_resolved)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // {resolved, bit} from the requirements
  function automatic logic [1:0] model(input logic [BUD-1:0] s);
    int v = MIDV;
    for (int t = 0; t < BUD; t++)
      if (v != 0 && v != TOPV) v = s[t] ? v + 1 : v - 1;
    return {(v == 0 || v == TOPV), (v == TOPV)};
  endfunction

  task automatic run_pass(input bit gaps, input bit poke_start);
    logic [1:0] exp;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 busy after start", busy, 1);
    for (int c = 0; c < NC; c++) begin
      exp = model(seq[c]);
      for (int t = 0; t < BUD; t++) begin
        if (gaps && ($urandom % 4 == 0)) begin
          samp_valid = 1'b0; samp_bits = NC'($urandom);
          @(negedge clk);
          chk("R10 no done in gap", done, 0);
        end
        chk("R7 cell_idx", cell_idx, c);
        samp_valid = 1'b1;
        samp_bits  = NC'($urandom);
        samp_bits[c] = seq[c][t];
        start = poke_start && (c == 1) && (t == 20);
        @(negedge clk);
        samp_valid = 1'b0; start = 1'b0;
        if (t == BUD - 1) begin
          chk("R8 done pulse", done, 1);
          chk("R8 done_idx", done_idx, c);
          chk("R5 R6 done_resolved", done_resolved, exp[1]);
          chk("R5 R6 done_bit", done_bit, exp[0]);
          chk("R9 busy at cell end", busy, (c != NC - 1) ? 1 : 0);
        end else begin
          chk("R8 no early done", done, 0);
        end
      end
    end
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R9 idle after pass", busy, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);

    // R10: idle samples are ignored
    for (int i = 0; i < 10; i++) begin
      samp_valid = 1'b1; samp_bits = NC'($urandom);
      @(negedge clk);
      chk("R10 idle busy", busy, 0);
      chk("R10 idle done", done, 0);
    end
    samp_valid = 1'b0;

    // directed: R2 preset, R3 steps, R4 hold, R5 mapping, R6 budget
    for (int t = 0; t < BUD; t++) begin
      seq[0][t] = (t < 7);
      seq[1][t] = (t < 6);
      seq[2][t] = (t % 2 == 0);
      seq[3][t] = 1'b0;
    end
    run_pass(1'b0, 1'b0);

    // directed: end reached on slot 49, near miss, start while busy (R9)
    for (int t = 0; t < BUD; t++) begin
      seq[0][t] = (t < 43) ? (t % 2 == 0) : (t < 49);
      seq[1][t] = (t < 43) ? (t % 2 == 0) : (t < 48);
      seq[2][t] = 1'b1;
      seq[3][t] = (t >= 6);
    end
    run_pass(1'b1, 1'b1);

    // random biased streams
    for (int p = 0; p < 12; p++) begin
      for (int c = 0; c < NC; c++) begin
        int bias = 20 + int'($urandom % 61);
        for (int t = 0; t < BUD; t++) seq[c][t] = (int'($urandom % 100) < bias);
      end
      run_pass(p[0], p[1]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule